// File: doc/BRIEF.md
# Stereo Audio Serial Port, Short-Frame Mode

This block is the master end of a stereo audio codec's serial data port running a short-frame DSP format. It has a receive side for the codec's converter output and a transmit side that feeds the codec's converter input. A separate divider supplies the bit clock. Both sides use that bit clock, and each side produces its own frame-sync pulse.

The bit clock is not used as a clock. It passes through a two-stage synchronizer in the system clock domain, and its rising and falling edges become single-cycle enable pulses. Every register therefore runs on the system clock.

A frame lasts `FRAME_LEN` bit clocks. Slot 0 carries the sync pulse. Slots 1 to `SAMPLE_W` carry the left sample, MSB first. The right sample follows in the next `SAMPLE_W` slots. The remaining slots of the frame are idle.

Outgoing sync and data change on the bit clock's falling edge. Incoming data is sampled on its rising edge. The receive side always runs. It presents each left/right pair as parallel words with a one-cycle valid strobe.

The transmit side starts a frame only while an upstream buffer reports that it holds data. At the start of each frame it takes the pair offered on its inputs and pulses a one-cycle fetch strobe.

Top module: `dsp_audio_port`

## Requirements
- R1: Out of reset, both frame-sync outputs, the serial output, the valid strobe, the fetch strobe and both received words are 0.
- R2: The receive-side sync is high for exactly one bit clock (slot 0) once every `FRAME_LEN` bit clocks. The first such slot begins at the first bit-clock falling edge after reset.
- R3: The receive side samples `adc_sdata_i` on bit-clock rising edges. Slots 1..`SAMPLE_W` form the left word, MSB first, and the next `SAMPLE_W` slots form the right word, MSB first. Data in slot 0 and in the idle slots is ignored.
- R4: After the rising edge of the last right-channel slot, `adc_valid_o` is high for one system clock. Both words update at that moment and hold until the next pair.
- R5: The receive side runs regardless of `dac_en_i`.
- R6: While the transmitter is idle, a bit-clock falling edge with `dac_en_i` high starts a frame. The transmit sync goes high for slot 0. `dac_fetch_o` pulses for one system clock while that sync is high, and the pair on `dac_left_i`/`dac_right_i` is captured in that cycle.
- R7: The transmitter drives the captured left word, MSB first, in slots 1..`SAMPLE_W`, then the right word, MSB first. Each bit changes after a bit-clock falling edge.
- R8: `dac_sdata_o` is 0 in slot 0, in the idle slots, and whenever the transmitter is idle.
- R9: Dropping `dac_en_i` in the middle of a frame does not cut that frame short. If `dac_en_i` is low at the end of a frame, no new sync pulse follows and the transmitter goes idle.
- R10: While `dac_en_i` stays high, transmit frames follow back to back, with one sync every `FRAME_LEN` bit clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk_i | input | 1 | Bit clock from the external divider |
| adc_sdata_i | input | 1 | Serial data from the codec's converter output |
| adc_fsync_o | output | 1 | Receive-side frame sync |
| adc_left_o | output | SAMPLE_W | Last received left sample |
| adc_right_o | output | SAMPLE_W | Last received right sample |
| adc_valid_o | output | 1 | One-cycle strobe when a new pair is ready |
| dac_en_i | input | 1 | Upstream buffer holds data; allows transmit frames |
| dac_left_i | input | SAMPLE_W | Left sample to transmit |
| dac_right_i | input | SAMPLE_W | Right sample to transmit |
| dac_fetch_o | output | 1 | One-cycle strobe when the offered pair is taken |
| dac_fsync_o | output | 1 | Transmit-side frame sync |
| dac_sdata_o | output | 1 | Serial data to the codec's converter input |

## Verification
The bench keeps `SAMPLE_W` at 16 but builds the block with `FRAME_LEN` = 64. The idle tail is still 31 slots, so the data window and the idle window stay clearly apart. The shorter frame lets roughly forty frames fit inside the cycle budget. That covers enable changes at the frame boundary, in the data window and in the idle tail, including runs of back-to-back frames and restarts from idle.

// File: rtl/dap_pkg.sv
package dap_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } bclk_evt_t;

  typedef enum logic [1:0] {
    SLOT_SYNC,
    SLOT_LEFT,
    SLOT_RIGHT,
    SLOT_IDLE
  } slot_kind_e;

  // Classifies a frame slot index for a given sample width.
  function automatic slot_kind_e slot_kind(input int unsigned slot,
                                           input int unsigned sample_w);
    if (slot == 0)                  return SLOT_SYNC;
    else if (slot <= sample_w)      return SLOT_LEFT;
    else if (slot <= 2 * sample_w)  return SLOT_RIGHT;
    else                            return SLOT_IDLE;
  endfunction

endpackage

// File: rtl/dap_rst_sync.sv
module dap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/dap_bclk_detect.sv
module dap_bclk_detect
  import dap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bclk_i,
  output bclk_evt_t evt_o
);
  // chain_q[SYNC_STAGES-1] is the synchronized level,
  // chain_q[SYNC_STAGES] is that level one cycle earlier.
  logic [SYNC_STAGES:0] chain_q;
  logic [SYNC_STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-1:0], bclk_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  always_comb begin
    evt_o.rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    evt_o.fall = ~chain_q[SYNC_STAGES-1] & chain_q[SYNC_STAGES];
  end
endmodule

// File: rtl/dap_frame_timer.sv
module dap_frame_timer #(
  parameter int FRAME_LEN = 256,
  localparam int SLOT_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              run_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              active_o,
  output logic              sync_o,
  output logic              start_o,
  output logic              adv_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              act_q, act_d;
  logic              sync_q, sync_d;
  logic              start_q, start_d;
  logic              adv_q, adv_d;

  always_comb begin
    slot_d  = slot_q;
    act_d   = act_q;
    sync_d  = sync_q;
    start_d = 1'b0;
    adv_d   = 1'b0;
    if (step_i) begin
      adv_d = 1'b1;
      if (act_q && (slot_q != LAST_SLOT)) begin
        slot_d = slot_q + 1'b1;
      end else if (run_i) begin
        slot_d  = '0;
        act_d   = 1'b1;
        start_d = 1'b1;
      end else begin
        slot_d = LAST_SLOT;
        act_d  = 1'b0;
      end
      sync_d = act_d && (slot_d == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= LAST_SLOT;
      act_q   <= 1'b0;
      sync_q  <= 1'b0;
      start_q <= 1'b0;
      adv_q   <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      act_q   <= act_d;
      sync_q  <= sync_d;
      start_q <= start_d;
      adv_q   <= adv_d;
    end
  end

  assign slot_o   = slot_q;
  assign active_o = act_q;
  assign sync_o   = sync_q;
  assign start_o  = start_q;
  assign adv_o    = adv_q;
endmodule

// File: rtl/dap_rx.sv
module dap_rx
  import dap_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FRAME_LEN = 256,
  localparam int SLOT_W = $clog2(FRAME_LEN),
  localparam int PAIR_W = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_i,
  input  logic                sdata_i,
  input  logic                active_i,
  input  logic [SLOT_W-1:0]   slot_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam logic [SLOT_W-1:0] LAST_DATA = SLOT_W'(PAIR_W);

  logic [PAIR_W-1:0]   shift_q, shift_d;
  logic [SAMPLE_W-1:0] left_q, left_d;
  logic [SAMPLE_W-1:0] right_q, right_d;
  logic                valid_q, valid_d;
  slot_kind_e          kind;

  always_comb begin
    kind    = slot_kind(32'(slot_i), SAMPLE_W);
    shift_d = shift_q;
    left_d  = left_q;
    right_d = right_q;
    valid_d = 1'b0;
    if (rise_i && active_i && (kind == SLOT_LEFT || kind == SLOT_RIGHT)) begin
      shift_d = {shift_q[PAIR_W-2:0], sdata_i};
      if (slot_i == LAST_DATA) begin
        left_d  = shift_d[PAIR_W-1:SAMPLE_W];
        right_d = shift_d[SAMPLE_W-1:0];
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      shift_q <= shift_d;
      left_q  <= left_d;
      right_q <= right_d;
      valid_q <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dap_tx.sv
module dap_tx
  import dap_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FRAME_LEN = 256,
  localparam int SLOT_W = $clog2(FRAME_LEN),
  localparam int PAIR_W = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv_i,
  input  logic                start_i,
  input  logic                active_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o
);
  logic [PAIR_W-1:0] shift_q, shift_d;
  logic              sd_q, sd_d;
  slot_kind_e        kind;

  always_comb begin
    kind    = slot_kind(32'(slot_i), SAMPLE_W);
    shift_d = shift_q;
    sd_d    = sd_q;
    if (start_i) begin
      shift_d = {left_i, right_i};
    end
    if (adv_i) begin
      if (active_i && (kind == SLOT_LEFT || kind == SLOT_RIGHT)) begin
        sd_d    = shift_q[PAIR_W-1];
        shift_d = {shift_q[PAIR_W-2:0], 1'b0};
      end else begin
        sd_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      sd_q    <= 1'b0;
    end else begin
      shift_q <= shift_d;
      sd_q    <= sd_d;
    end
  end

  assign sdata_o = sd_q;
endmodule

// File: rtl/dsp_audio_port.sv
module dsp_audio_port
  import dap_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int FRAME_LEN   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                adc_sdata_i,
  output logic                adc_fsync_o,
  output logic [SAMPLE_W-1:0] adc_left_o,
  output logic [SAMPLE_W-1:0] adc_right_o,
  output logic                adc_valid_o,
  input  logic                dac_en_i,
  input  logic [SAMPLE_W-1:0] dac_left_i,
  input  logic [SAMPLE_W-1:0] dac_right_i,
  output logic                dac_fetch_o,
  output logic                dac_fsync_o,
  output logic                dac_sdata_o
);
  localparam int SLOT_W = $clog2(FRAME_LEN);

  logic              rst_n_s;
  bclk_evt_t         evt;
  logic              bclk_fall;
  logic [SLOT_W-1:0] rx_slot, tx_slot;
  logic              rx_act, tx_act;
  logic              rx_start, rx_adv;
  logic              tx_start, tx_adv;

  dap_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  dap_bclk_detect #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst_n(rst_n_s), .bclk_i(bclk_i), .evt_o(evt)
  );

  assign bclk_fall = evt.fall;

  // Receive side: always enabled, so its timer never stops.
  dap_frame_timer #(.FRAME_LEN(FRAME_LEN)) rx_tmr_i (
    .clk(clk), .rst_n(rst_n_s), .step_i(evt.fall), .run_i(1'b1),
    .slot_o(rx_slot), .active_o(rx_act), .sync_o(adc_fsync_o),
    .start_o(rx_start), .adv_o(rx_adv)
  );

  dap_rx #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN)) rx_i (
    .clk(clk), .rst_n(rst_n_s), .rise_i(evt.rise), .sdata_i(adc_sdata_i),
    .active_i(rx_act), .slot_i(rx_slot),
    .left_o(adc_left_o), .right_o(adc_right_o), .valid_o(adc_valid_o)
  );

  // Transmit side: a frame starts only when upstream has data.
  dap_frame_timer #(.FRAME_LEN(FRAME_LEN)) tx_tmr_i (
    .clk(clk), .rst_n(rst_n_s), .step_i(evt.fall), .run_i(dac_en_i),
    .slot_o(tx_slot), .active_o(tx_act), .sync_o(dac_fsync_o),
    .start_o(tx_start), .adv_o(tx_adv)
  );

  dap_tx #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN)) tx_i (
    .clk(clk), .rst_n(rst_n_s), .adv_i(tx_adv), .start_i(tx_start),
    .active_i(tx_act), .slot_i(tx_slot),
    .left_i(dac_left_i), .right_i(dac_right_i), .sdata_o(dac_sdata_o)
  );

  assign dac_fetch_o = tx_start;

  // The receive timer's start and step strobes are not needed downstream.
  logic unused_rx;
  assign unused_rx = rx_start ^ rx_adv;
endmodule

// File: rtl/dap_checker.sv
module dap_checker #(
  parameter int FRAME_LEN = 256
) (
  input logic clk,
  input logic rst_n,
  input logic bclk_fall,
  input logic adc_fsync,
  input logic adc_valid,
  input logic dac_fsync,
  input logic dac_sdata,
  input logic dac_fetch
);
  localparam int CW = $clog2(FRAME_LEN) + 1;

  logic [CW-1:0] fall_cnt;
  logic          seen;
  logic          fsync_q;
  logic          fsync_rose;

  assign fsync_rose = adc_fsync & ~fsync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt <= '0;
      seen     <= 1'b0;
      fsync_q  <= 1'b0;
    end else begin
      fsync_q <= adc_fsync;
      if (fsync_rose) begin
        fall_cnt <= '0;
        seen     <= 1'b1;
      end else if (bclk_fall && (fall_cnt != CW'(FRAME_LEN))) begin
        fall_cnt <= fall_cnt + 1'b1;
      end
    end
  end

  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_rose && seen) |-> (fall_cnt == CW'(FRAME_LEN))); // R2

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid |=> !adc_valid); // R4

  AST_VALID_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid |-> !adc_fsync); // R3

  AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_fetch |=> !dac_fetch); // R6

  AST_FETCH_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    dac_fetch |-> dac_fsync); // R6

  AST_SYNC_BRINGS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_fsync) |-> dac_fetch); // R6

  AST_SDATA_LOW_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    dac_fsync |-> !dac_sdata); // R8
endmodule

bind dsp_audio_port dap_checker #(.FRAME_LEN(FRAME_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall),
  .adc_fsync(adc_fsync_o), .adc_valid(adc_valid_o),
  .dac_fsync(dac_fsync_o), .dac_sdata(dac_sdata_o), .dac_fetch(dac_fetch_o)
);

// File: tb/dsp_audio_port_tb_top.sv
module dsp_audio_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW   = 16;
  localparam int FL   = 64;
  localparam int PW   = 2 * SW;
  localparam int HALF = 6;
  localparam int NFRAMES = 40;

  logic          clk, rst_n, bclk, adc_sdata, dac_en;
  logic          adc_fsync, adc_valid, dac_fetch, dac_fsync, dac_sdata;
  logic [SW-1:0] adc_left, adc_right, dac_left, dac_right;

  int vectors = 0;
  int fails   = 0;
  int valid_seen = 0;
  int fetch_seen = 0;
  logic [SW-1:0] got_left, got_right;

  dsp_audio_port #(.SAMPLE_W(SW), .FRAME_LEN(FL)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .adc_sdata_i(adc_sdata),
    .adc_fsync_o(adc_fsync), .adc_left_o(adc_left), .adc_right_o(adc_right),
    .adc_valid_o(adc_valid), .dac_en_i(dac_en), .dac_left_i(dac_left),
    .dac_right_i(dac_right), .dac_fetch_o(dac_fetch),
    .dac_fsync_o(dac_fsync), .dac_sdata_o(dac_sdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (adc_valid) begin
      valid_seen <= valid_seen + 1;
      got_left   <= adc_left;
      got_right  <= adc_right;
    end
    if (dac_fetch) fetch_seen <= fetch_seen + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected transmit bit for a slot of an active frame.
  function automatic logic tx_bit(input int slot, input logic [PW-1:0] pair);
    if (slot >= 1 && slot <= PW) return pair[PW - slot];
    return 1'b0;
  endfunction

  // Bench model state
  int            rx_slot = FL - 1;
  logic [PW-1:0] adc_pair;
  int            tx_slot = FL - 1;
  bit            tx_act  = 0;
  bit            tx_b2b  = 0;
  logic [PW-1:0] tx_pair;
  int            exp_fetch = 0;
  int            exp_valid = 0;
  int            frame = 0;
  int            en_slot = 0;
  bit            en_val  = 0;

  initial begin
    void'($urandom(32'h00C0DEC5));
    rst_n = 1'b0; bclk = 1'b1; adc_sdata = 1'b0; dac_en = 1'b0;
    dac_left = SW'($urandom); dac_right = SW'($urandom);
    adc_pair = '0; tx_pair = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    // R1 reset state
    chk("R1 adc_fsync", 64'(adc_fsync), 0);
    chk("R1 dac_fsync", 64'(dac_fsync), 0);
    chk("R1 dac_sdata", 64'(dac_sdata), 0);
    chk("R1 valid/fetch", 64'({adc_valid, dac_fetch}), 0);
    chk("R1 words", 64'({adc_left, adc_right}), 0);

    while (frame < NFRAMES) begin
      // ---- falling edge of the bit clock ----
      @(negedge clk);
      bclk = 1'b0;
      rx_slot = (rx_slot + 1) % FL;
      if (rx_slot == 0) begin
        frame++;
        adc_pair = {SW'($urandom), SW'($urandom)};
        if (frame == 6) adc_pair = {SW'(16'h8000), SW'(16'h0001)};
        if (frame == 7) adc_pair = {SW'(16'hFFFF), SW'(16'h0000)};
        // enable schedule: directed corners, then random
        if (frame < 4)       begin en_slot = 0;  en_val = 0; end
        else if (frame == 4) begin en_slot = 5;  en_val = 1; end
        else if (frame == 9) begin en_slot = 10; en_val = 0; end
        else if (frame == 11) begin en_slot = 40; en_val = 1; end
        else if (frame < 15) begin en_slot = 0; en_val = dac_en; end
        else begin en_slot = int'($urandom % FL); en_val = bit'($urandom % 2); end
      end
      if (rx_slot >= 1 && rx_slot <= PW) adc_sdata = adc_pair[PW - rx_slot];
      else adc_sdata = 1'($urandom);
      // transmit model, using enable as seen at this edge
      if (tx_act && tx_slot != FL - 1) tx_slot++;
      else if (dac_en) begin
        tx_b2b = tx_act; tx_act = 1; tx_slot = 0;
        tx_pair = {dac_left, dac_right}; exp_fetch++;
      end else begin tx_act = 0; tx_slot = FL - 1; end
      repeat (HALF - 1) @(negedge clk);
      chk("R2 adc_fsync", 64'(adc_fsync), 64'(rx_slot == 0));
      chk(tx_slot == 0 && tx_act ? (tx_b2b ? "R10 dac_fsync" : "R6 dac_fsync") :
          (dac_en ? "R6 dac_fsync" : "R9 dac_fsync"),
          64'(dac_fsync), 64'(tx_act && tx_slot == 0));
      chk(!tx_act ? "R8 dac_sdata idle" :
          (tx_slot == 0 || tx_slot > PW) ? "R8 dac_sdata" :
          (dac_en ? "R7 dac_sdata" : "R9 dac_sdata"),
          64'(dac_sdata), 64'(tx_act ? tx_bit(tx_slot, tx_pair) : 1'b0));
      chk("R6 fetch count", 64'(fetch_seen), 64'(exp_fetch));
      if (tx_act && tx_slot == 0) begin
        dac_left = SW'($urandom); dac_right = SW'($urandom);
      end
      if (rx_slot == en_slot) dac_en = en_val;
      @(negedge clk);
      // ---- rising edge of the bit clock ----
      bclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
      if (rx_slot == PW) begin
        exp_valid++;
        chk(dac_en ? "R4 left word" : "R5 left word", 64'(got_left), 64'(adc_pair[PW-1:SW]));
        chk("R3 right word", 64'(got_right), 64'(adc_pair[SW-1:0]));
        chk("R4 held words", 64'({adc_left, adc_right}), 64'(adc_pair));
      end
      chk("R4 valid count", 64'(valid_seen), 64'(exp_valid));
      @(negedge clk);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    vectors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule